// File: doc/BRIEF.md
# Cascaded-Slice Arithmetic/Logic Unit with Side Shifter

This block is a purely combinational arithmetic and logic unit for a narrow datapath. It is built from a row of identical 4-bit function-select slices. All slices share one 4-bit function select and one mode bit, and the carry out of each slice ripples into the carry in of the next. Two single-position shifters sit beside the slice row and work on operand A. An output multiplexer picks between the slice-row result and one of the shifters.

A small lookup-table decoder, indexed by a 3-bit operation code, produces every internal control: the slice function select, the mode bit, the carry in of the first slice, the output source and whether the carry flag is exported. The surrounding datapath presents the operands and the code and takes the result in the same cycle. The block holds no state and has no handshake, so it applies no back-pressure. Its width is the slice width times the slice count.

Top module: `cslice_alu16`

## Requirements
- R1: Code 3'b000 (add) gives result = (a + b) mod 2^W, and carry_o equals bit W of the full sum.
- R2: Code 3'b001 (subtract) gives result = (a - b) mod 2^W, and carry_o is 1 exactly when a >= b as unsigned numbers (no borrow).
- R3: Code 3'b010 gives the bitwise AND of a and b, with carry_o = 0.
- R4: Code 3'b011 gives the bitwise OR of a and b, with carry_o = 0. Alternating patterns such as 0x555 and 0xAAA combine to all ones over their width.
- R5: Code 3'b100 shifts a left by one place: bit 0 of the result is 0, each higher bit n takes a[n-1], and carry_o = 0.
- R6: Code 3'b101 shifts a right by one place: the top bit of the result is 0, each lower bit n takes a[n+1], and carry_o = 0.
- R7: Codes 3'b110 and 3'b111 give result = 0 and carry_o = 0.
- R8: zero_o is 1 exactly when the selected W-bit result is all zeros, for every code.
- R9: Carries ripple across slice boundaries. 0x0FFF + 1 gives 0x1000, and 0xFFFF + 1 gives 0 with carry_o = 1 and zero_o = 1 at the default width.
- R10: The datapath width W equals SLICE_W * NUM_SLICES. A three-slice build is a 12-bit unit that obeys R1 to R8 over 12 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code |
| a_i | input | W | Operand A, also the shift source |
| b_i | input | W | Operand B |
| result_o | output | W | Selected result |
| carry_o | output | 1 | Carry out of the last slice for add and subtract, otherwise 0 |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The bench builds two copies. The first uses the defaults, four slices of 4 bits for a 16-bit unit. The second uses NUM_SLICES = 3 for a 12-bit unit. The 16-bit copy covers carries crossing every slice boundary, wrap-around to zero with carry set, and borrow on subtraction. The 12-bit copy covers the narrower width, where 0x555 OR 0xAAA must fill every bit and the shifters must drop the edge bit at bit 11 rather than bit 15.

// File: rtl/cslice_alu_pkg.sv
package cslice_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_SHL = 3'b100,
    OP_SHR = 3'b101
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_CHAIN = 2'd0,
    SRC_SHL   = 2'd1,
    SRC_SHR   = 2'd2,
    SRC_NONE  = 2'd3
  } alu_src_e;

  typedef struct packed {
    logic [3:0] fsel;
    logic       mode;     // 1 = logic, 0 = arithmetic
    logic       cin;
    alu_src_e   src;
    logic       cout_en;
  } alu_ctrl_t;

  localparam int NUM_OPS = 8;

  function automatic alu_ctrl_t ctrl_word(input int code);
    alu_ctrl_t w;
    w = '{fsel: 4'b0000, mode: 1'b1, cin: 1'b0, src: SRC_NONE, cout_en: 1'b0};
    case (code)
      0: w = '{fsel: 4'b1001, mode: 1'b0, cin: 1'b0, src: SRC_CHAIN, cout_en: 1'b1};
      1: w = '{fsel: 4'b0110, mode: 1'b0, cin: 1'b1, src: SRC_CHAIN, cout_en: 1'b1};
      2: w = '{fsel: 4'b1011, mode: 1'b1, cin: 1'b0, src: SRC_CHAIN, cout_en: 1'b0};
      3: w = '{fsel: 4'b1110, mode: 1'b1, cin: 1'b0, src: SRC_CHAIN, cout_en: 1'b0};
      4: w.src = SRC_SHL;
      5: w.src = SRC_SHR;
      default: ;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/alu_op_rom.sv
module alu_op_rom
  import cslice_alu_pkg::*;
(
  input  logic [2:0] op_i,
  output alu_ctrl_t  ctrl_o
);
  alu_ctrl_t rom_w [NUM_OPS];

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_rom
    assign rom_w[g] = ctrl_word(g);
  end

  assign ctrl_o = rom_w[op_i];
endmodule

// File: rtl/alu_slice.sv
module alu_slice #(
  parameter int W = 4
) (
  input  logic [3:0]   fsel_i,
  input  logic         mode_i,
  input  logic         cin_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] f_o,
  output logic         cout_o
);
  logic [W-1:0] x_w, y_w;
  logic [W:0]   c_w;

  // Per-bit operand terms chosen by the function select.
  assign x_w = a_i | (b_i & {W{fsel_i[0]}}) | (~b_i & {W{fsel_i[1]}});
  assign y_w = (a_i & ~b_i & {W{fsel_i[2]}}) | (a_i & b_i & {W{fsel_i[3]}});

  always_comb begin
    c_w[0] = cin_i;
    for (int i = 0; i < W; i++) begin
      c_w[i+1] = (x_w[i] & y_w[i]) | ((x_w[i] ^ y_w[i]) & c_w[i]);
    end
  end

  assign f_o    = mode_i ? ~(x_w ^ y_w) : (x_w ^ y_w ^ c_w[W-1:0]);
  assign cout_o = mode_i ? 1'b0 : c_w[W];
endmodule

// File: rtl/alu_shift1.sv
module alu_shift1 #(
  parameter int W    = 16,
  parameter bit LEFT = 1'b1
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (LEFT) begin : g_left
    assign q_o = {d_i[W-2:0], 1'b0};
  end else begin : g_right
    assign q_o = {1'b0, d_i[W-1:1]};
  end
endmodule

// File: rtl/cslice_alu16.sv
module cslice_alu16
  import cslice_alu_pkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 4
) (
  input  logic [2:0]                    op_i,
  input  logic [SLICE_W*NUM_SLICES-1:0] a_i,
  input  logic [SLICE_W*NUM_SLICES-1:0] b_i,
  output logic [SLICE_W*NUM_SLICES-1:0] result_o,
  output logic                          carry_o,
  output logic                          zero_o
);
  localparam int DATA_W = SLICE_W * NUM_SLICES;

  alu_ctrl_t           ctrl_w;
  logic [NUM_SLICES:0] chain_c;
  logic [DATA_W-1:0]   chain_f, shl_f, shr_f;

  alu_op_rom u_rom (.op_i(op_i), .ctrl_o(ctrl_w));

  assign chain_c[0] = ctrl_w.cin;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    alu_slice #(.W(SLICE_W)) u_slice (
      .fsel_i (ctrl_w.fsel),
      .mode_i (ctrl_w.mode),
      .cin_i  (chain_c[s]),
      .a_i    (a_i[s*SLICE_W +: SLICE_W]),
      .b_i    (b_i[s*SLICE_W +: SLICE_W]),
      .f_o    (chain_f[s*SLICE_W +: SLICE_W]),
      .cout_o (chain_c[s+1])
    );
  end

  alu_shift1 #(.W(DATA_W), .LEFT(1'b1)) u_shl (.d_i(a_i), .q_o(shl_f));
  alu_shift1 #(.W(DATA_W), .LEFT(1'b0)) u_shr (.d_i(a_i), .q_o(shr_f));

  always_comb begin
    case (ctrl_w.src)
      SRC_CHAIN: result_o = chain_f;
      SRC_SHL:   result_o = shl_f;
      SRC_SHR:   result_o = shr_f;
      default:   result_o = '0;
    endcase
  end

  assign carry_o = ctrl_w.cout_en & chain_c[NUM_SLICES];
  assign zero_o  = ~|result_o;
endmodule

// File: rtl/cslice_alu16_chk.sv
module cslice_alu16_chk #(
  parameter int W = 16
) (
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] result_o,
  input logic         carry_o,
  input logic         zero_o
);
  logic [W:0] sum_w, diff_w;
  assign sum_w  = {1'b0, a_i} + {1'b0, b_i};
  assign diff_w = {1'b0, a_i} - {1'b0, b_i};

  always_comb begin
    if (op_i == 3'b000) begin
      // R1
      add_sum_chk: assert ({carry_o, result_o} == sum_w);
    end
    if (op_i == 3'b001) begin
      // R2
      sub_diff_chk: assert (result_o == diff_w[W-1:0] && carry_o == (a_i >= b_i));
    end
    if (op_i == 3'b010) begin
      // R3
      and_bits_chk: assert (result_o == (a_i & b_i) && !carry_o);
    end
    if (op_i == 3'b011) begin
      // R4
      or_bits_chk: assert (result_o == (a_i | b_i) && !carry_o);
    end
    if (op_i == 3'b100) begin
      // R5
      shl_lsb_chk: assert (!result_o[0] && result_o[W-1:1] == a_i[W-2:0] && !carry_o);
    end
    if (op_i == 3'b101) begin
      // R6
      shr_msb_chk: assert (!result_o[W-1] && result_o[W-2:0] == a_i[W-1:1] && !carry_o);
    end
    if (op_i[2:1] == 2'b11) begin
      // R7
      unused_zero_chk: assert (result_o == '0 && !carry_o);
    end
    // R8
    zero_flag_chk: assert (zero_o == (result_o == '0));
  end
endmodule

bind cslice_alu16 cslice_alu16_chk #(.W(SLICE_W * NUM_SLICES)) u_chk (
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .result_o (result_o),
  .carry_o  (carry_o),
  .zero_o   (zero_o)
);

// File: tb/cslice_alu16_tb.sv
module cslice_alu16_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [2:0]  op16 = 3'd0, op12 = 3'd0;
  logic [15:0] a16 = '0, b16 = '0, r16;
  logic [11:0] a12 = '0, b12 = '0, r12;
  logic        c16, z16, c12, z12;

  cslice_alu16 u_dut (
    .op_i(op16), .a_i(a16), .b_i(b16),
    .result_o(r16), .carry_o(c16), .zero_o(z16)
  );

  cslice_alu16 #(.SLICE_W(4), .NUM_SLICES(3)) u_dut12 (
    .op_i(op12), .a_i(a12), .b_i(b12),
    .result_o(r12), .carry_o(c12), .zero_o(z12)
  );

  task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // Drive at the falling edge, sample 2 ns later (combinational path).
  task automatic run16(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    op16 = op; a16 = a; b16 = b;
    #2;
  endtask

  task automatic run12(input logic [2:0] op, input logic [11:0] a, input logic [11:0] b);
    @(negedge clk);
    op12 = op; a12 = a; b12 = b;
    #2;
  endtask

  // Expected {zero, carry, result} for the 16-bit copy.
  function automatic logic [17:0] model16(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    logic [15:0] r;
    logic        c;
    c = 1'b0;
    case (op)
      3'd0: begin s = {1'b0, a} + {1'b0, b}; r = s[15:0]; c = s[16]; end
      3'd1: begin r = a - b; c = (a >= b); end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a * 2;
      3'd5: r = a / 2;
      default: r = '0;
    endcase
    return {(r == 16'd0), c, r};
  endfunction

  function automatic logic [17:0] model12(input logic [2:0] op, input logic [11:0] a, input logic [11:0] b);
    logic [12:0] s;
    logic [11:0] r;
    logic        c;
    c = 1'b0;
    case (op)
      3'd0: begin s = {1'b0, a} + {1'b0, b}; r = s[11:0]; c = s[12]; end
      3'd1: begin r = a - b; c = (a >= b); end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a * 2;
      3'd5: r = a / 2;
      default: r = '0;
    endcase
    return {4'd0, (r == 12'd0), c, r};
  endfunction

  task automatic t16(input string req, input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    run16(op, a, b);
    check(req, {z16, c16, r16}, model16(op, a, b));
  endtask

  task automatic t12(input string req, input logic [2:0] op, input logic [11:0] a, input logic [11:0] b);
    run12(op, a, b);
    check(req, {4'd0, z12, c12, r12}, model12(op, a, b));
  endtask

  task automatic test_idle;
    #3;
    check("R8 idle zero flag", {z16, c16, r16}, {1'b1, 1'b0, 16'h0000});
  endtask

  task automatic test_add;
    t16("R1 add small", 3'd0, 16'h1234, 16'h0101);
    t16("R1 add carry out", 3'd0, 16'h8000, 16'h8001);
    t16("R1 add mixed", 3'd0, 16'hA5A5, 16'h3C3C);
  endtask

  task automatic test_sub;
    t16("R2 sub no borrow", 3'd1, 16'h5000, 16'h1234);
    t16("R2 sub borrow", 3'd1, 16'h0001, 16'h0002);
    t16("R2 sub equal", 3'd1, 16'h7777, 16'h7777);
    run16(3'd1, 16'h0003, 16'h0005);
    check("R2 sub wrap", {z16, c16, r16}, {1'b0, 1'b0, 16'hFFFE});
  endtask

  task automatic test_logic;
    t16("R3 and", 3'd2, 16'hF0F0, 16'hFF00);
    t16("R3 and disjoint", 3'd2, 16'h5555, 16'hAAAA);
    t16("R4 or", 3'd3, 16'h0555, 16'h0AAA);
    run16(3'd3, 16'h0555, 16'h0AAA);
    check("R4 or literal", {z16, c16, r16}, {1'b0, 1'b0, 16'h0FFF});
    t16("R4 or carry-like bits", 3'd3, 16'hFFFF, 16'h0001);
  endtask

  task automatic test_shift;
    t16("R5 shl", 3'd4, 16'h8001, 16'hFFFF);
    run16(3'd4, 16'hC003, 16'h0000);
    check("R5 shl literal", {z16, c16, r16}, {1'b0, 1'b0, 16'h8006});
    t16("R6 shr", 3'd5, 16'h8001, 16'hFFFF);
    run16(3'd5, 16'hC003, 16'h0000);
    check("R6 shr literal", {z16, c16, r16}, {1'b0, 1'b0, 16'h6001});
    t16("R8 shr to zero", 3'd5, 16'h0001, 16'h0000);
  endtask

  task automatic test_unused;
    run16(3'd6, 16'hFFFF, 16'hFFFF);
    check("R7 code 110", {z16, c16, r16}, {1'b1, 1'b0, 16'h0000});
    run16(3'd7, 16'h1234, 16'h8765);
    check("R7 code 111", {z16, c16, r16}, {1'b1, 1'b0, 16'h0000});
  endtask

  task automatic test_ripple;
    run16(3'd0, 16'h0FFF, 16'h0001);
    check("R9 ripple 0FFF+1", {z16, c16, r16}, {1'b0, 1'b0, 16'h1000});
    run16(3'd0, 16'hFFFF, 16'h0001);
    check("R9 ripple wrap", {z16, c16, r16}, {1'b1, 1'b1, 16'h0000});
    run16(3'd0, 16'h00FF, 16'h0001);
    check("R9 ripple 00FF+1", {z16, c16, r16}, {1'b0, 1'b0, 16'h0100});
  endtask

  task automatic test_narrow;
    run12(3'd3, 12'h555, 12'hAAA);
    check("R10 R4 12-bit or", {4'd0, z12, c12, r12}, {4'd0, 1'b0, 1'b0, 12'hFFF});
    run12(3'd0, 12'hFFF, 12'h001);
    check("R10 R9 12-bit wrap", {4'd0, z12, c12, r12}, {4'd0, 1'b1, 1'b1, 12'h000});
    t12("R10 R2 12-bit sub", 3'd1, 12'h123, 12'h456);
    t12("R10 R5 12-bit shl", 3'd4, 12'h801, 12'h000);
    t12("R10 R6 12-bit shr", 3'd5, 12'h801, 12'h000);
    t12("R10 R3 12-bit and", 3'd2, 12'hF0F, 12'h3C3);
    t12("R10 R7 12-bit unused", 3'd6, 12'hABC, 12'hDEF);
  endtask

  initial begin
    test_idle();
    test_add();
    test_sub();
    test_logic();
    test_shift();
    test_unused();
    test_ripple();
    test_narrow();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule